// File: doc/BRIEF.md
# Port Group ID Allocator

This block hands out free entries of a port-group-ID table and takes them back. It keeps one in-use bit for each entry of the table. A client raises `alloc_req` for one cycle. In the next cycle the block either pulses `alloc_valid` with the granted ID on `alloc_id`, or pulses `alloc_fail` when no ID can be handed out. A client hands an ID back by raising `rel_req` with the ID on `rel_id`.

The low end of the table is held back permanently for fixed uses: destination masks, flood masks and CPU forwarding. Those entries are never granted. The entries above that block form a pool shared by multicast, link aggregation and virtualization profiles. Inside that pool, a sub-range kept for link aggregation is also excluded. The search for a free ID does not begin at the pool base. It begins a fixed offset above it, and it always returns the lowest free ID it finds from there.

Top module: `pgid_alloc`

## Requirements
- R1: After reset, `alloc_valid`, `alloc_fail` and `rel_err` are 0 and every entry is free, so the first grant is ID START = RESV_LOW + SEARCH_OFS (80 with the default parameters).
- R2: No ID below START is ever granted. This covers the RESV_LOW fixed entries (0..71) and the first SEARCH_OFS pool entries (72..79).
- R3: No ID in the protected range AGG_LO..AGG_HI (inclusive, 200..215 by default) is ever granted.
- R4: A one-cycle `alloc_req` is answered exactly one cycle later. The answer is a one-cycle `alloc_valid` with `alloc_id` set to the lowest free eligible ID, and that ID becomes used.
- R5: When no eligible ID is free, `alloc_req` gives a one-cycle `alloc_fail` with `alloc_valid` at 0, and no entry changes state.
- R6: Releasing a used ID makes it free, so a later allocation can grant it again. `rel_err` stays 0.
- R7: Releasing an ID that is not eligible (below START, or in AGG_LO..AGG_HI) or that is already free changes nothing. `rel_err` pulses high for one cycle, one cycle after `rel_req`.
- R8: An allocation and a release in the same cycle both take effect. The allocation sees the table as it was before the release, so the released ID cannot be granted in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Request one free ID |
| alloc_valid | output | 1 | Grant pulse, one cycle after the request |
| alloc_fail | output | 1 | No eligible ID was free |
| alloc_id | output | IDW | Granted ID |
| rel_req | input | 1 | Hand back the ID on `rel_id` |
| rel_id | input | IDW | ID being handed back |
| rel_err | output | 1 | The release was ignored |

## Verification
A wrong in-use bit shows up as a grant that is out of order: a grant that skips a free ID, repeats an ID already held, or a failure while eligible IDs remain. Each of these appears on the first allocation after the bit goes wrong. A bit that gets stuck can stay hidden until the table fills up. For that reason the bench fills every eligible entry, with ascending IDs expected, and then checks for failure, release and reuse. A bad eligibility mask shows up as a grant below START or inside the protected range, or as a missing `rel_err` for such an ID, one cycle after the request.

// File: rtl/pgid_alloc.sv
module pgid_alloc #(
  parameter int N          = 256,
  parameter int RESV_LOW   = 72,
  parameter int SEARCH_OFS = 8,
  parameter int AGG_LO     = 200,
  parameter int AGG_HI     = 215,
  localparam int IDW       = $clog2(N),
  localparam int START     = RESV_LOW + SEARCH_OFS
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           alloc_req,
  output logic           alloc_valid,
  output logic           alloc_fail,
  output logic [IDW-1:0] alloc_id,
  input  logic           rel_req,
  input  logic [IDW-1:0] rel_id,
  output logic           rel_err
);

  logic [N-1:0]   used, elig, set_m, clr_m;
  logic [IDW-1:0] pick;
  logic           hit, rel_ok;

  for (genvar i = 0; i < N; i++) begin : g_elig
    assign elig[i] = (i >= START) && !((i >= AGG_LO) && (i <= AGG_HI));
  end

  always_comb begin
    hit  = 1'b0;
    pick = '0;
    for (int i = N - 1; i >= 0; i--)
      if (elig[i] && !used[i]) begin
        hit  = 1'b1;
        pick = IDW'(i);
      end
  end

  assign rel_ok = (int'(rel_id) < N) && elig[rel_id] && used[rel_id];

  always_comb begin
    set_m = '0;
    clr_m = '0;
    if (alloc_req && hit) set_m[pick]   = 1'b1;
    if (rel_req && rel_ok) clr_m[rel_id] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used        <= '0;
      alloc_valid <= 1'b0;
      alloc_fail  <= 1'b0;
      alloc_id    <= '0;
      rel_err     <= 1'b0;
    end else begin
      used        <= (used | set_m) & ~clr_m;
      alloc_valid <= alloc_req && hit;
      alloc_fail  <= alloc_req && !hit;
      rel_err     <= rel_req && !rel_ok;
      if (alloc_req && hit) alloc_id <= pick;
    end
  end

endmodule

// File: rtl/pgid_alloc_chk.sv
module pgid_alloc_chk #(
  parameter int N = 256, RESV_LOW = 72, SEARCH_OFS = 8, AGG_LO = 200, AGG_HI = 215,
  localparam int IDW = $clog2(N),
  localparam int START = RESV_LOW + SEARCH_OFS
) (
  input logic           clk,
  input logic           rst_n,
  input logic           alloc_req,
  input logic           alloc_valid,
  input logic           alloc_fail,
  input logic [IDW-1:0] alloc_id,
  input logic           rel_req,
  input logic           rel_err,
  input logic [N-1:0]   used
);

  a_r2_above_start: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid |-> int'(alloc_id) >= START);

  a_r3_skip_protected: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid |-> !((int'(alloc_id) >= AGG_LO) && (int'(alloc_id) <= AGG_HI)));

  a_r4_answer_once: assert property (@(posedge clk) disable iff (!rst_n)
    $past(alloc_req) |-> (alloc_valid ^ alloc_fail));

  a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(alloc_req) |-> (!alloc_valid && !alloc_fail));

  a_r4_grant_marked: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid |-> used[alloc_id]);

  a_r5_fail_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_fail && !$past(rel_req)) |-> (used == $past(used)));

  a_r7_err_needs_release: assert property (@(posedge clk) disable iff (!rst_n)
    rel_err |-> $past(rel_req));

endmodule

bind pgid_alloc pgid_alloc_chk #(
  .N(N), .RESV_LOW(RESV_LOW), .SEARCH_OFS(SEARCH_OFS), .AGG_LO(AGG_LO), .AGG_HI(AGG_HI)
) chk_i (
  .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_valid(alloc_valid),
  .alloc_fail(alloc_fail), .alloc_id(alloc_id), .rel_req(rel_req),
  .rel_err(rel_err), .used(used)
);

// File: tb/pgid_alloc_tb_top.sv
module pgid_alloc_tb_top;
  localparam int N = 256, START = 80, AGG_LO = 200, AGG_HI = 215, IDW = 8;

  logic clk = 1'b0, rst_n = 1'b0, alloc_req = 1'b0, rel_req = 1'b0;
  logic [IDW-1:0] rel_id = '0, alloc_id;
  logic alloc_valid, alloc_fail, rel_err;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pgid_alloc dut_i (.clk(clk), .rst_n(rst_n), .alloc_req(alloc_req),
    .alloc_valid(alloc_valid), .alloc_fail(alloc_fail), .alloc_id(alloc_id),
    .rel_req(rel_req), .rel_id(rel_id), .rel_err(rel_err));

  // vector: {op(1: release), arg[7:0], exp_ok, exp_id[7:0], exp_err}
  localparam int NV = 12;
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 8'd0,   1'b1, 8'd80, 1'b0},   // R1 first grant at START
    {1'b0, 8'd0,   1'b1, 8'd81, 1'b0},   // R4
    {1'b0, 8'd0,   1'b1, 8'd82, 1'b0},   // R4
    {1'b1, 8'd81,  1'b0, 8'd0,  1'b0},   // R6
    {1'b0, 8'd0,   1'b1, 8'd81, 1'b0},   // R6 reuse
    {1'b1, 8'd10,  1'b0, 8'd0,  1'b1},   // R7 fixed entry
    {1'b1, 8'd75,  1'b0, 8'd0,  1'b1},   // R7 below start
    {1'b1, 8'd90,  1'b0, 8'd0,  1'b1},   // R7 already free
    {1'b1, 8'd205, 1'b0, 8'd0,  1'b1},   // R7 protected
    {1'b0, 8'd0,   1'b1, 8'd83, 1'b0},   // R4
    {1'b1, 8'd80,  1'b0, 8'd0,  1'b0},   // R6
    {1'b1, 8'd80,  1'b0, 8'd0,  1'b1}    // R7 double release
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic op(input bit a, input bit r, input int id);
    @(negedge clk);
    alloc_req = a; rel_req = r; rel_id = IDW'(id);
    @(negedge clk);
    alloc_req = 1'b0; rel_req = 1'b0;
  endtask

  task automatic do_alloc(input bit exp_ok, input int exp_id, input string req);
    op(1'b1, 1'b0, 0);
    chk(alloc_valid == exp_ok && alloc_fail == !exp_ok, req, {alloc_valid, alloc_fail}, {exp_ok, !exp_ok});
    if (exp_ok) chk(int'(alloc_id) == exp_id, req, alloc_id, exp_id);
  endtask

  task automatic do_rel(input int id, input bit exp_err, input string req);
    op(1'b0, 1'b1, id);
    chk(rel_err == exp_err, req, rel_err, exp_err);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic fill(output int cnt);
    cnt = 0;
    for (int i = START; i < N; i++)
      if (i < AGG_LO || i > AGG_HI) begin
        do_alloc(1'b1, i, "R2/R3/R4 fill");
        cnt++;
      end
  endtask

  initial begin
    int c;
    repeat (3) @(negedge clk);
    chk(!alloc_valid && !alloc_fail && !rel_err, "R1 reset outputs", {alloc_valid, alloc_fail, rel_err}, 0);
    rst_n = 1'b1;
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][18]) do_rel(int'(VEC[v][17:10]), VEC[v][0], "R6/R7 vector");
      else do_alloc(VEC[v][9], int'(VEC[v][8:1]), "R1/R4 vector");
    end

    do_reset();
    chk(!alloc_valid && !alloc_fail && !rel_err, "R1 reset outputs", {alloc_valid, alloc_fail, rel_err}, 0);
    fill(c);
    chk(c == 160, "R2/R3 eligible count", c, 160);
    do_alloc(1'b0, 0, "R5 full table fails");
    do_alloc(1'b0, 0, "R5 still full");
    do_rel(210, 1'b1, "R7 protected release");
    do_rel(150, 1'b0, "R6 release used");
    do_alloc(1'b1, 150, "R6 reuse after release");
    do_alloc(1'b0, 0, "R5 full again");

    // R8: alloc and release together on a full table
    op(1'b1, 1'b1, 100);
    chk(alloc_fail && !alloc_valid, "R8 alloc sees old state", {alloc_valid, alloc_fail}, 1);
    chk(!rel_err, "R8 release accepted", rel_err, 0);
    do_alloc(1'b1, 100, "R8 released id granted next");

    // R8: alloc and release with free IDs present
    do_rel(90, 1'b0, "R6 release 90");
    do_rel(91, 1'b0, "R6 release 91");
    op(1'b1, 1'b1, 85);
    chk(alloc_valid && int'(alloc_id) == 90, "R8 lowest before release", alloc_id, 90);
    do_alloc(1'b1, 85, "R8 release effective");
    do_alloc(1'b1, 91, "R4 lowest free");

    do_reset();
    do_alloc(1'b1, 80, "R1 reset clears table");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule